// File: doc/BRIEF.md
# Parallel BCH(63,57) Systematic Encoder

This block turns a 57-bit message into a 63-bit BCH codeword within one clock. The block does not divide the message by the code's generator polynomial one bit at a time. It forms the six check bits as a vector–matrix product over GF(2): each check bit is the XOR of the message bits picked out by one column of a constant parity matrix. That matrix is derived at elaboration from the generator polynomial x^6 + x^5 + 1. Row j of the matrix is the remainder of x^(6+j) divided by that polynomial, with coefficients reduced mod 2.

The codeword is systematic. Its upper 57 bits repeat the message unchanged, and its lower 6 bits hold the check bits. Bit 0 is the x^0 coefficient, so the 63-bit word read as a polynomial is always a multiple of the generator. A message with its strobe raised is captured at a clock edge. Because the logic is fully parallel, a new message can be accepted on every clock.

A two-state output machine records whether the output register holds a word that is fresh this cycle. **EMPTY** leads to **LOADED** when a message is captured (transition CAPTURE). **LOADED** stays in **LOADED** on a back-to-back capture (transition STREAM). **LOADED** returns to **EMPTY** on a cycle without a message (transition DRAIN). **EMPTY** stays in **EMPTY** while no message arrives (transition WAIT). Reset forces **EMPTY**.

Top module: `bchx_enc63`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next clock edge clears `cw_valid` to 0 and `cw_data` to all zeros, even if `msg_valid` is high.
- R2: One clock after an edge where `msg_valid` is 1, `cw_data[62:6]` equals the `msg_data[56:0]` sampled at that edge, bit for bit.
- R3: In the same cycle, `cw_data[5:0]` equals the remainder of msg(x)·x^6 divided by x^6+x^5+1, with bit i as the x^i coefficient. For example, a message with only bit 0 set gives 6'b100001, and one with only bit 1 set gives 6'b100011.
- R4: Whenever `cw_valid` is 1, the 63-bit `cw_data` read as a polynomial (bit i = x^i) has a zero remainder modulo x^6+x^5+1.
- R5: `cw_valid` is 1 in exactly the cycles that follow an edge where `msg_valid` was 1 outside reset. Back-to-back messages each produce their own codeword on consecutive cycles.
- R6: At an edge where `msg_valid` is 0, `msg_data` is ignored: `cw_data` keeps its previous value.
- R7: The all-zero message encodes to the all-zero codeword. The encoding is linear: the codeword of A xor B equals the codeword of A xor the codeword of B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | 1 | Message present this cycle |
| msg_data | input | 57 | Message, bit j weighted x^(6+j) in the codeword |
| cw_valid | output | 1 | Codeword register holds a word captured at the last edge |
| cw_data | output | 63 | Registered codeword: message in [62:6], check bits in [5:0] |

## Verification
The hardest behaviour to reach from the ports is this one: every check-bit column must be shown to have the right weight, and a column that is off by one can still give a valid-looking codeword for many messages. The stimulus therefore sends a walking single 1 across all 57 message positions, so that each matrix row appears alone at the output. It then sends streams of pseudo-random words back to back and with gaps, and changes `msg_data` while `msg_valid` is low to show that the word is held. It also pairs message encodings to test linearity, and raises reset in the middle of a stream while a message is being offered.

// File: rtl/bchx_pkg.sv
package bchx_pkg;

    // Code geometry
    localparam int CW_BITS  = 63;
    localparam int MSG_BITS = 57;
    localparam int CHK_BITS = CW_BITS - MSG_BITS;

    // Generator polynomial without its leading x^CHK_BITS term:
    // x^6 + x^5 + 1  ->  low part x^5 + 1
    localparam logic [CHK_BITS-1:0] GEN_LOW = 6'b100001;

    typedef logic [MSG_BITS-1:0] msg_t;
    typedef logic [CW_BITS-1:0]  cw_t;
    typedef logic [CHK_BITS-1:0] chk_t;

    // One mask per check bit: mask[p][j] is set when x^(CHK_BITS+j) mod g
    // has a 1 in position p (a column of the parity matrix).
    typedef logic [CHK_BITS-1:0][MSG_BITS-1:0] colmask_t;

    typedef enum logic [0:0] {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } ostate_t;

    function automatic colmask_t build_col_masks(input chk_t glow);
        colmask_t   masks;
        chk_t       rem;
        logic       carry;
        masks = '0;
        rem   = glow;                 // x^CHK_BITS mod g
        for (int j = 0; j < MSG_BITS; j++) begin
            for (int p = 0; p < CHK_BITS; p++) begin
                masks[p][j] = rem[p];
            end
            carry = rem[CHK_BITS-1];
            rem   = {rem[CHK_BITS-2:0], 1'b0} ^ (carry ? glow : '0);
        end
        return masks;
    endfunction

endpackage

// File: rtl/bchx_parity_tree.sv
module bchx_parity_tree
    import bchx_pkg::*;
#(
    parameter int         KB   = MSG_BITS,
    parameter int         RB   = CHK_BITS,
    parameter logic [RB-1:0] GLOW = GEN_LOW
) (
    input  logic [KB-1:0] msg,
    output logic [RB-1:0] chk
);

    localparam colmask_t MASKS = build_col_masks(GLOW);

    // One XOR reduction per check bit: the GF(2) dot product of the
    // message with one column of the parity matrix.
    for (genvar p = 0; p < RB; p++) begin : g_col
        logic [KB-1:0] picked;
        assign picked = msg & MASKS[p];
        assign chk[p] = ^picked;
    end

endmodule

// File: rtl/bchx_out_stage.sv
module bchx_out_stage
    import bchx_pkg::*;
#(
    parameter int KB = MSG_BITS,
    parameter int RB = CHK_BITS,
    localparam int NB = KB + RB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [KB-1:0] msg,
    input  logic [RB-1:0] chk,
    output logic          valid,
    output logic [NB-1:0] word
);

    ostate_t state_q, state_d;
    logic [NB-1:0] word_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  state_d = load ? ST_LOADED : ST_EMPTY;   // CAPTURE / WAIT
            ST_LOADED: state_d = load ? ST_LOADED : ST_EMPTY;   // STREAM / DRAIN
            default:   state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: codeword captured only on a load
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= {msg, chk};
        end
    end

    assign valid = (state_q == ST_LOADED);
    assign word  = word_q;

endmodule

// File: rtl/bchx_enc63.sv
module bchx_enc63
    import bchx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                msg_valid,
    input  logic [MSG_BITS-1:0] msg_data,
    output logic                cw_valid,
    output logic [CW_BITS-1:0]  cw_data
);

    chk_t chk_w;

    bchx_parity_tree #(
        .KB   (MSG_BITS),
        .RB   (CHK_BITS),
        .GLOW (GEN_LOW)
    ) u_tree (
        .msg (msg_data),
        .chk (chk_w)
    );

    bchx_out_stage #(
        .KB (MSG_BITS),
        .RB (CHK_BITS)
    ) u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (msg_valid),
        .msg   (msg_data),
        .chk   (chk_w),
        .valid (cw_valid),
        .word  (cw_data)
    );

endmodule

// File: rtl/bchx_enc63_chk.sv
module bchx_enc63_chk
    import bchx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                msg_valid,
    input logic [MSG_BITS-1:0] msg_data,
    input logic                cw_valid,
    input logic [CW_BITS-1:0]  cw_data
);

    // Long division of the whole word, one coefficient at a time
    function automatic chk_t word_rem(input cw_t w);
        chk_t r;
        logic fb;
        r = '0;
        for (int i = CW_BITS - 1; i >= 0; i--) begin
            fb = r[CHK_BITS-1];
            r  = {r[CHK_BITS-2:0], w[i]} ^ (fb ? GEN_LOW : '0);
        end
        return r;
    endfunction

    // R5: valid follows the input strobe by one cycle
    a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> cw_valid);
    a_r5_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |=> !cw_valid);

    // R2: message copied into the upper field
    a_r2_msg_field: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> (cw_data[CW_BITS-1:CHK_BITS] == $past(msg_data)));

    // R6: word held when no message is offered
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |=> $stable(cw_data));

    // R4: every presented word is a multiple of the generator
    a_r4_divisible: assert property (@(posedge clk) disable iff (rst)
        cw_valid |-> (word_rem(cw_data) == '0));

endmodule

bind bchx_enc63 bchx_enc63_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg_data  (msg_data),
    .cw_valid  (cw_valid),
    .cw_data   (cw_data)
);

// File: tb/sim_bchx_enc63.sv
`timescale 1ns/1ps
module sim_bchx_enc63;

    localparam int N = 63;
    localparam int K = 57;
    localparam int R = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         msg_valid = 1'b0;
    logic [K-1:0] msg_data = '0;
    logic         cw_valid;
    logic [N-1:0] cw_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bchx_enc63 u0 (
        .clk       (clk),
        .rst       (rst),
        .msg_valid (msg_valid),
        .msg_data  (msg_data),
        .cw_valid  (cw_valid),
        .cw_data   (cw_data)
    );

    // Reference: remainder of poly mod x^6+x^5+1, via an integer loop
    function automatic logic [R-1:0] poly_mod(input logic [N-1:0] p);
        logic [N-1:0] t;
        t = p;
        for (int i = N - 1; i >= R; i--) begin
            if (t[i]) begin
                t[i]     = 1'b0;
                t[i-1]   = ~t[i-1];   // x^5 term of g shifted
                t[i-R]   = ~t[i-R];   // constant term of g shifted
            end
        end
        return t[R-1:0];
    endfunction

    function automatic logic [N-1:0] ref_encode(input logic [K-1:0] m);
        return {m, poly_mod({m, {R{1'b0}}})};
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle model of the registered output
    logic         exp_v  = 1'b0;
    logic [N-1:0] exp_cw = '0;
    always @(posedge clk) begin
        if (rst) begin
            exp_v  <= 1'b0;
            exp_cw <= '0;
        end else begin
            exp_v <= msg_valid;
            if (msg_valid) exp_cw <= ref_encode(msg_data);
        end
    end

    // Compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done && !rst) begin
            check("R5 cw_valid", {62'b0, cw_valid}, {62'b0, exp_v});
            check("R2/R3/R6 cw_data", cw_data, exp_cw);
            if (cw_valid) check("R4 remainder", {57'b0, poly_mod(cw_data)}, '0);
        end
    end

    task automatic send(input logic [K-1:0] m);
        @(posedge clk); #2;
        msg_valid = 1'b1;
        msg_data  = m;
    endtask

    task automatic idle(input int n, input logic [K-1:0] noise);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            msg_valid = 1'b0;
            msg_data  = noise ^ K'(i);
        end
    endtask

    // Send one word, then look at the result
    task automatic send_and_see(input logic [K-1:0] m, output logic [N-1:0] got);
        send(m);
        idle(1, ~m);
        @(negedge clk);
        got = cw_data;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 0);
        $finish;
    end

    initial begin : stim
        logic [N-1:0] wa, wb, wx;
        logic [K-1:0] a, b;
        repeat (3) @(posedge clk);
        #2 msg_valid = 1'b1; msg_data = {K{1'b1}};
        @(posedge clk); #2;
        @(negedge clk);
        // R1: reset dominates an offered message
        check("R1 reset valid", {62'b0, cw_valid}, '0);
        check("R1 reset data", cw_data, '0);
        @(posedge clk); #2 rst = 1'b0; msg_valid = 1'b0;

        // R7: zero message
        send_and_see('0, wx);
        check("R7 zero", wx, '0);
        // R3: single-bit rows
        send_and_see(57'd1, wx);
        check("R3 bit0 parity", {57'b0, wx[5:0]}, {57'b0, 6'b100001});
        send_and_see(57'd2, wx);
        check("R3 bit1 parity", {57'b0, wx[5:0]}, {57'b0, 6'b100011});

        // Walking one through every row, back to back
        for (int j = 0; j < K; j++) send(57'd1 << j);
        idle(3, 57'h0AB_CDEF_0123_4567);

        // Random streams with gaps, noise while idle (R6)
        for (int i = 0; i < 400; i++) begin
            send({$urandom, $urandom});
            if (($urandom % 4) == 0) idle(1 + ($urandom % 3), {$urandom, $urandom});
        end
        idle(2, '1);

        // R7 linearity
        for (int i = 0; i < 8; i++) begin
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            send_and_see(a, wa);
            send_and_see(b, wb);
            send_and_see(a ^ b, wx);
            check("R7 linear", wx, wa ^ wb);
        end

        // R1 mid-stream reset with message offered
        send(57'h155_5555_5555_5555);
        @(posedge clk); #2 rst = 1'b1; msg_valid = 1'b1;
        @(posedge clk); #2;
        @(negedge clk);
        check("R1 mid reset valid", {62'b0, cw_valid}, '0);
        check("R1 mid reset data", cw_data, '0);
        @(posedge clk); #2 rst = 1'b0; msg_valid = 1'b0;
        send({K{1'b1}});
        idle(3, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 0);
        $finish;
    end

endmodule